// File: doc/BRIEF.md
# Stereo Sample Crossbar with Deferred Default Routing

This block steers digital stereo sample streams through a full crossbar. Four stereo input pairs arrive as parallel sample words. Any pair can be sent to either of two stereo output pairs and to the source select of an external processing path. The three selections are held in one routing register. A simple register bus writes that register: a subaddress, a data word and a write strobe. Each output pair carries its left and right words together. The registered outputs take a new sample only when the sample-valid strobe is high, so a routing change never tears a word.

The routing register has no reset. A system reset does not touch it. A reset only arms a one-bit "default pending" flag. The default routing is loaded by the first write to the baseband subaddress 0x12 that follows the reset. If software writes the routing register first, its value stays and the pending default is dropped. While standby is high, the crossbar keeps both its routing and its data flow, and it ignores the bus. When standby is released, the pending flag is armed again and the current routing stays in place.

Top module: `route_matrix`

## Requirements
- R1: The routing register sits at subaddress 0x20 and takes bits [5:0] of the write data. Bits [1:0] pick the processing source, bits [3:2] pick the source of output A and bits [5:4] pick the source of output B. A field value n selects input pair n (0 to 3, which is bits [16n+15:16n] of the input buses). Every one of the 64 routing values is legal.
- R2: The left and right words of each destination always come from the same input pair.
- R3: The destination outputs load on a clock edge where sampleValid is high. On every other edge they hold their value.
- R4: While rstN is low, all destination outputs are zero. A reset leaves the routing register unchanged.
- R5: After a reset, the first write to subaddress 0x12 loads the default routing 0x10 (processing and output A from pair 0, output B from pair 1).
- R6: A routing write that comes after a reset and before any write to 0x12 is kept. A later write to 0x12 does not replace it.
- R7: Once the pending default has been used, further writes to 0x12 do not change the routing.
- R8: Writes to any other subaddress change neither the routing nor the pending default.
- R9: While standby is high, bus writes are ignored, the routing holds, and samples keep passing on sampleValid.
- R10: When standby is released, the routing is kept unchanged and the default is armed again, so the next write to 0x12 loads it.
- R11: A sample captured on the same edge as a routing write uses the old routing. The new routing applies from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby: hold routing, ignore the bus |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write subaddress |
| wrData | input | 6 | Write data (routing fields) |
| sampleValid | input | 1 | A new sample is present on the inputs |
| inLeft | input | 64 | Left words of the four input pairs |
| inRight | input | 64 | Right words of the four input pairs |
| outALeft | output | 16 | Output A left |
| outARight | output | 16 | Output A right |
| outBLeft | output | 16 | Output B left |
| outBRight | output | 16 | Output B right |
| procLeft | output | 16 | Processing-path left |
| procRight | output | 16 | Processing-path right |

## Verification
The assertions check on every cycle that the outputs hold between sample strobes, and that a routing write lands in the register. They also check that the default lands when it is pending, that writes to unrelated subaddresses leave the pending flag alone, and that leaving standby re-arms the flag. Some behaviour shows only across a whole sequence of events: the routing surviving a reset, the order of the first routing write against the first 0x12 write, and standby ignoring the bus. The bench's scenarios cover these. The bench also sweeps all 64 routing values with distinct sample words on every pair.

// File: rtl/route_pkg.sv
package route_pkg;
  // destination indices; field order in the routing register follows them
  localparam int DST_PROC = 0;
  localparam int DST_A    = 1;
  localparam int DST_B    = 2;
  localparam int NUM_DST  = 3;

  typedef struct packed {
    logic capture;      // take a new sample on every destination
    logic routeWrite;   // load routing register from bus data
    logic defaultLoad;  // load deferred default routing
  } ctrlStrobes_t;
endpackage

// File: rtl/route_ctrl.sv
module route_ctrl
  import route_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] ROUTE_ADDR = 'h20,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 'h12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              sampleValid,
  output ctrlStrobes_t      strobes
);
  logic standbyQ;
  logic pending;
  logic busOk;
  logic hitRoute;
  logic hitBase;
  logic exitStandby;

  assign busOk       = wrEn && !standby && rstN;
  assign hitRoute    = busOk && (wrAddr == ROUTE_ADDR);
  assign hitBase     = busOk && (wrAddr == BASE_ADDR);
  assign exitStandby = standbyQ && !standby;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      standbyQ <= 1'b0;
      pending  <= 1'b1;
    end else begin
      standbyQ <= standby;
      if (exitStandby)
        pending <= 1'b1;
      else if (hitRoute || hitBase)
        pending <= 1'b0;
    end
  end

  always_comb begin
    strobes.capture     = sampleValid;
    strobes.routeWrite  = hitRoute;
    strobes.defaultLoad = hitBase && pending;
  end

  // R8: unrelated subaddress leaves the pending flag alone
  assert_other_addr_keeps_pending_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != ROUTE_ADDR && wrAddr != BASE_ADDR && !standbyQ && !standby)
      |=> (pending == $past(pending)));

  // R10: leaving standby arms the default again
  assert_exit_rearms_R10: assert property (@(posedge clk) disable iff (!rstN)
    exitStandby |=> pending);

  // R9: no bus effect while in standby
  assert_standby_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (standby && standbyQ) |=> (pending == $past(pending)));
endmodule

// File: rtl/route_datapath.sv
module route_datapath
  import route_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned SEL_W     = $clog2(NUM_PAIRS),
  parameter int unsigned ROUTE_W   = NUM_DST * SEL_W,
  parameter int unsigned DEFAULT_ROUTE = 'h10
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strobes,
  input  logic [ROUTE_W-1:0]            wrData,
  input  logic [NUM_PAIRS*SAMPLE_W-1:0] inLeft,
  input  logic [NUM_PAIRS*SAMPLE_W-1:0] inRight,
  output logic [NUM_DST*SAMPLE_W-1:0]   outLeft,
  output logic [NUM_DST*SAMPLE_W-1:0]   outRight
);
  localparam logic [ROUTE_W-1:0] DEF_ROUTE = DEFAULT_ROUTE[ROUTE_W-1:0];

  logic [ROUTE_W-1:0]  routeReg;
  logic [SAMPLE_W-1:0] pairLeft  [NUM_PAIRS];
  logic [SAMPLE_W-1:0] pairRight [NUM_PAIRS];

  // routing register: deliberately without reset
  always_ff @(posedge clk) begin
    if (strobes.routeWrite)
      routeReg <= wrData;
    else if (strobes.defaultLoad)
      routeReg <= DEF_ROUTE;
  end

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    assign pairLeft[p]  = inLeft[p*SAMPLE_W +: SAMPLE_W];
    assign pairRight[p] = inRight[p*SAMPLE_W +: SAMPLE_W];
  end

  for (genvar d = 0; d < NUM_DST; d++) begin : g_dst
    logic [SEL_W-1:0] sel;
    assign sel = routeReg[d*SEL_W +: SEL_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outLeft[d*SAMPLE_W +: SAMPLE_W]  <= '0;
        outRight[d*SAMPLE_W +: SAMPLE_W] <= '0;
      end else if (strobes.capture) begin
        outLeft[d*SAMPLE_W +: SAMPLE_W]  <= pairLeft[sel];
        outRight[d*SAMPLE_W +: SAMPLE_W] <= pairRight[sel];
      end
    end
  end

  // R3: outputs only move on a capture strobe
  assert_hold_without_capture_R3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.capture |=> ($stable(outLeft) && $stable(outRight)));

  // R6: a bus write lands in the routing register
  assert_route_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.routeWrite |=> (routeReg == $past(wrData)));

  // R5: a pending default lands on the baseband write
  assert_default_load_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.defaultLoad && !strobes.routeWrite) |=> (routeReg == DEF_ROUTE));
endmodule

// File: rtl/route_matrix.sv
module route_matrix
  import route_pkg::*;
#(
  parameter int unsigned SAMPLE_W  = 16,
  parameter int unsigned NUM_PAIRS = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ROUTE_ADDR = 'h20,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 'h12,
  parameter int unsigned DEFAULT_ROUTE = 'h10,
  localparam int unsigned SEL_W   = $clog2(NUM_PAIRS),
  localparam int unsigned ROUTE_W = NUM_DST * SEL_W
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          standby,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [ROUTE_W-1:0]            wrData,
  input  logic                          sampleValid,
  input  logic [NUM_PAIRS*SAMPLE_W-1:0] inLeft,
  input  logic [NUM_PAIRS*SAMPLE_W-1:0] inRight,
  output logic [SAMPLE_W-1:0]           outALeft,
  output logic [SAMPLE_W-1:0]           outARight,
  output logic [SAMPLE_W-1:0]           outBLeft,
  output logic [SAMPLE_W-1:0]           outBRight,
  output logic [SAMPLE_W-1:0]           procLeft,
  output logic [SAMPLE_W-1:0]           procRight
);
  ctrlStrobes_t                strobes;
  logic [NUM_DST*SAMPLE_W-1:0] dstLeft;
  logic [NUM_DST*SAMPLE_W-1:0] dstRight;

  route_ctrl #(
    .ADDR_W(ADDR_W), .ROUTE_ADDR(ROUTE_ADDR), .BASE_ADDR(BASE_ADDR)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .standby(standby), .wrEn(wrEn),
    .wrAddr(wrAddr), .sampleValid(sampleValid), .strobes(strobes)
  );

  route_datapath #(
    .SAMPLE_W(SAMPLE_W), .NUM_PAIRS(NUM_PAIRS), .SEL_W(SEL_W),
    .ROUTE_W(ROUTE_W), .DEFAULT_ROUTE(DEFAULT_ROUTE)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .inLeft(inLeft), .inRight(inRight),
    .outLeft(dstLeft), .outRight(dstRight)
  );

  assign procLeft  = dstLeft[DST_PROC*SAMPLE_W +: SAMPLE_W];
  assign procRight = dstRight[DST_PROC*SAMPLE_W +: SAMPLE_W];
  assign outALeft  = dstLeft[DST_A*SAMPLE_W +: SAMPLE_W];
  assign outARight = dstRight[DST_A*SAMPLE_W +: SAMPLE_W];
  assign outBLeft  = dstLeft[DST_B*SAMPLE_W +: SAMPLE_W];
  assign outBRight = dstRight[DST_B*SAMPLE_W +: SAMPLE_W];
endmodule

// File: tb/test_route_matrix.sv
module test_route_matrix;
  logic        clk = 1'b0;
  logic        rstN;
  logic        standby;
  logic        wrEn;
  logic [7:0]  wrAddr;
  logic [5:0]  wrData;
  logic        sampleValid;
  logic [63:0] inLeft;
  logic [63:0] inRight;
  logic [15:0] outALeft, outARight, outBLeft, outBRight, procLeft, procRight;

  int compared = 0;
  int mismatched = 0;
  int tag = 1;

  always #4 clk = ~clk;

  route_matrix i_route_matrix (
    .clk(clk), .rstN(rstN), .standby(standby), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .sampleValid(sampleValid), .inLeft(inLeft), .inRight(inRight),
    .outALeft(outALeft), .outARight(outARight), .outBLeft(outBLeft),
    .outBRight(outBRight), .procLeft(procLeft), .procRight(procRight)
  );

  function automatic logic [15:0] pairWord(int p, int t, bit right);
    return {right, 3'(p), 12'(t)};
  endfunction

  function automatic logic [15:0] getOut(int d, bit right);
    case (d)
      0: return right ? procRight : procLeft;
      1: return right ? outARight : outALeft;
      default: return right ? outBRight : outBLeft;
    endcase
  endfunction

  task automatic check(logic [15:0] act, logic [15:0] exp, string req);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic driveInputs(int t);
    for (int p = 0; p < 4; p++) begin
      inLeft[p*16 +: 16]  = pairWord(p, t, 1'b0);
      inRight[p*16 +: 16] = pairWord(p, t, 1'b1);
    end
  endtask

  task automatic writeReg(logic [7:0] a, logic [5:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pushSample(int t);
    @(negedge clk);
    driveInputs(t);
    sampleValid = 1'b1;
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  // expected pair for destination d is field (route >> 2d) & 3
  task automatic compareRoute(logic [5:0] r, int t, string req);
    for (int d = 0; d < 3; d++) begin
      int p = int'((r >> (2 * d)) & 6'd3);
      check(getOut(d, 1'b0), pairWord(p, t, 1'b0), req);
      check(getOut(d, 1'b1), pairWord(p, t, 1'b1), req);
    end
  endtask

  task automatic checkRoute(logic [5:0] r, string req);
    pushSample(tag);
    compareRoute(r, tag, req);
    tag++;
  endtask

  task automatic checkZero(string req);
    for (int d = 0; d < 3; d++) begin
      check(getOut(d, 1'b0), 16'h0, req);
      check(getOut(d, 1'b1), 16'h0, req);
    end
  endtask

  task automatic pulseReset();
    @(negedge clk);
    rstN = 1'b0;
    #1;
    checkZero("R4 outputs cleared");
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; standby = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    sampleValid = 1'b0; inLeft = '0; inRight = '0;
    repeat (3) @(negedge clk);
    checkZero("R4 reset state");
    rstN = 1'b1;

    // R8 then R5: other subaddress keeps the default pending
    writeReg(8'h30, 6'h2A);
    writeReg(8'h12, 6'h3F);
    checkRoute(6'h10, "R5 R8 default after first baseband write");

    // R1 R2: sweep all routing values
    for (int r = 0; r < 64; r++) begin
      writeReg(8'h20, 6'(r));
      checkRoute(6'(r), "R1 R2 sweep");
    end

    // R7: default already used
    writeReg(8'h12, 6'h00);
    checkRoute(6'h3F, "R7 baseband write after default used");

    // R3: no capture -> hold
    @(negedge clk);
    driveInputs(tag + 100);
    repeat (5) @(negedge clk);
    compareRoute(6'h3F, tag - 1, "R3 hold without sampleValid");

    // R11: capture on the same edge as a routing write uses the old routing
    writeReg(8'h20, 6'h00);
    checkRoute(6'h00, "R11 setup");
    @(negedge clk);
    wrEn = 1'b1; wrAddr = 8'h20; wrData = 6'h39;
    driveInputs(tag); sampleValid = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; sampleValid = 1'b0;
    compareRoute(6'h00, tag, "R11 old routing on write edge");
    tag++;
    checkRoute(6'h39, "R11 new routing next edge");

    // R4 routing survives reset; R6 early routing write wins
    writeReg(8'h20, 6'h1B);
    pulseReset();
    checkRoute(6'h1B, "R4 routing kept over reset");
    writeReg(8'h20, 6'h27);
    writeReg(8'h12, 6'h00);
    checkRoute(6'h27, "R6 early routing write kept");

    // R8 with pending default armed, then R5
    pulseReset();
    writeReg(8'h11, 6'h01);
    writeReg(8'h13, 6'h02);
    checkRoute(6'h27, "R8 other subaddress no routing change");
    writeReg(8'h12, 6'h00);
    checkRoute(6'h10, "R5 default after reset");

    // R9 standby ignores bus, keeps passing samples
    writeReg(8'h20, 6'h39);
    @(negedge clk);
    standby = 1'b1;
    writeReg(8'h20, 6'h00);
    writeReg(8'h12, 6'h00);
    checkRoute(6'h39, "R9 standby holds routing");
    checkRoute(6'h39, "R9 standby passes samples");

    // R10 leaving standby re-arms default
    @(negedge clk);
    standby = 1'b0;
    checkRoute(6'h39, "R10 routing kept on standby exit");
    writeReg(8'h12, 6'h00);
    checkRoute(6'h10, "R10 default after standby exit");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule